// File: doc/BRIEF.md
# Set-Associative Copyback Data Cache Controller

This block runs lookup and miss handling for an 8-way set-associative data cache on a 32-bit byte address. It holds the tag, valid bit and dirty bit of every block in flops. It compares the tags of all eight ways of the addressed set in one cycle. Word data lives in an external single-port data array with a one-cycle read latency. The controller drives that array through an index built as `{set, way, word}`, so the index is 12 bits at default parameters.

On a miss, a separate replacement unit supplies the victim way on `victim_way_i`. If the victim is valid and dirty, its 16 words go back to memory first. The whole 64-byte block is then fetched over a word-wide request/acknowledge memory port. The fetch starts at the requested word and wraps around the block. A store that misses fetches the block and merges its data into the requested word.

A base/limit window on the tag bits marks one range of addresses as non-cacheable. Accesses in that range go straight to memory as single-word transactions. A constant output reports the cache geometry. The controller accepts one access at a time, when `ready_o` is high. Each access ends with a one-cycle pulse on `resp_valid_o`.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset, `ready_o` is 1 and both `resp_valid_o` and `mem_req_o` are 0. Every block is invalid, so the first access misses and refills.
- R2: The address splits into three fields: bits [5:2] select the word, bits [10:6] the set and bits [31:11] the tag. Addresses that differ only in the tag compete for the same set.
- R3: Load and store hits raise `resp_valid_o` on the third rising edge after the edge that accepted the request. A hit causes no memory transaction.
- R4: A refill reads all 16 words of the block at `{tag, set, word, 2'b00}`. It starts at the requested word and continues with word (previous+1) mod 16.
- R5: A store hit marks its block dirty and writes nothing to memory. A later load of that word returns the stored data.
- R6: A store miss refills the block with reads only. It then holds the store data in the requested word, and memory keeps its old value.
- R7: A valid, dirty victim is first written back as 16 writes, words 0 to 15 in ascending order, to the victim's own address. Only then is the first refill read issued.
- R8: An invalid victim, or a valid clean one, is replaced with no write to memory.
- R9: An access whose tag satisfies `nc_base_i <= tag < nc_limit_i` makes exactly one memory transaction at its own word address. The data is never allocated, so a repeated access goes to memory again.
- R10: The window bounds are exact. Tag `nc_limit_i` and tag `nc_base_i - 1` are cacheable, while tag `nc_limit_i - 1` is not.
- R11: `geom_o` reads `{sets[31:16], ways[15:8], block_bytes[7:0]}`, which is 0x0020_0840 at default parameters.
- R12: Every load returns the value most recently stored to its address, across hits, refills and evictions.
- R13: On a miss, only the way given by `victim_way_i` is replaced. The other ways of the set still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when `ready_o` is high |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data |
| ready_o | output | 1 | Controller idle, can accept a request |
| resp_valid_o | output | 1 | One-cycle pulse when the access completes |
| rdata_o | output | 32 | Load data, valid with `resp_valid_o` |
| victim_way_i | input | 3 | Way to replace, from the replacement unit |
| nc_base_i | input | 21 | Lowest non-cacheable tag |
| nc_limit_i | input | 21 | First cacheable tag above the window |
| geom_o | output | 32 | Geometry: sets, ways, block bytes |
| da_en_o | output | 1 | Data array access enable |
| da_we_o | output | 1 | Data array write |
| da_idx_o | output | 12 | Data array index `{set, way, word}` |
| da_wdata_o | output | 32 | Data array write data |
| da_rdata_i | input | 32 | Data array read data, one cycle after enable |
| mem_req_o | output | 1 | Memory word transfer request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory transfer done, one cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with `mem_ack_i` |

## Verification
The hardest case to reach is a dirty eviction whose written-back block also carries a word merged by an earlier store. Reaching it needs a store hit, then a miss on a different tag in the same set, with `victim_way_i` pointing at the dirty way. The bench builds this by filling two ways of one set under chosen victims, dirtying one of them, and evicting it with a third tag. It then checks two things:
- the write-back burst comes before any refill read and carries the stored word;
- the untouched way still hits afterwards.

Clean evictions and accesses at the exact edges of the non-cacheable window are reached the same way, by steering the victim and the tag.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_RESP_A, ST_RESP_B,
    ST_WB_RD, ST_WB_WR, ST_FILL, ST_NC
  } dc_state_e;
endpackage

// File: rtl/dcache_tag_match.sv
module dcache_tag_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 21
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        check_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [WAYS-1:0]             valid_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic                        hit_o,
  output logic [$clog2(WAYS)-1:0]     way_o
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_o = |match;
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way_o = WAY_W'(w);
    end
  end

  // R2: a tag lives in at most one way of a set
  a_r2_unique_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_i |-> $onehot0(match));
endmodule

// File: rtl/dcache_nc_window.sv
module dcache_nc_window #(
  parameter int TAG_W = 21
) (
  input  logic [TAG_W-1:0] base_i,
  input  logic [TAG_W-1:0] limit_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o
);
  assign hit_o = (tag_i >= base_i) && (tag_i < limit_i);
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int WAYS        = 8,
  parameter int SETS        = 32,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int WORDS  = BLOCK_BYTES / (DATA_W / 8),
  localparam int WORD_W = $clog2(WORDS),
  localparam int OFF_W  = BYTE_W + WORD_W,
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int IDX_W  = SET_W + WAY_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [WAY_W-1:0]  victim_way_i,
  input  logic [TAG_W-1:0]  nc_base_i,
  input  logic [TAG_W-1:0]  nc_limit_i,
  output logic [31:0]       geom_o,
  output logic              da_en_o,
  output logic              da_we_o,
  output logic [IDX_W-1:0]  da_idx_o,
  output logic [DATA_W-1:0] da_wdata_o,
  input  logic [DATA_W-1:0] da_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

  dc_state_e st_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0]            valid_q, dirty_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [WAY_W-1:0]  way_q;
  logic [WORD_W-1:0] cnt_q, fill_word_q;
  logic              resp_q;

  logic [TAG_W-1:0]  tag_a;
  logic [SET_W-1:0]  set_a;
  logic [WORD_W-1:0] word_a;
  logic              hit, nc_hit;
  logic [WAY_W-1:0]  hit_way;

  assign tag_a  = addr_q[ADDR_W-1:OFF_W+SET_W];
  assign set_a  = addr_q[OFF_W+SET_W-1:OFF_W];
  assign word_a = addr_q[OFF_W-1:BYTE_W];

  dcache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .check_i (st_q == ST_LOOKUP),
    .tags_i  (tag_q[set_a]),
    .valid_i (valid_q[set_a]),
    .tag_i   (tag_a),
    .hit_o   (hit),
    .way_o   (hit_way)
  );

  dcache_nc_window #(.TAG_W(TAG_W)) u_nc (
    .base_i  (nc_base_i),
    .limit_i (nc_limit_i),
    .tag_i   (tag_a),
    .hit_o   (nc_hit)
  );

  assign geom_o       = {16'(SETS), 8'(WAYS), 8'(BLOCK_BYTES)};
  assign ready_o      = (st_q == ST_IDLE);
  assign resp_valid_o = resp_q;
  assign rdata_o      = rdata_q;

  always_comb begin
    da_en_o     = 1'b0;
    da_we_o     = 1'b0;
    da_idx_o    = {set_a, hit_way, word_a};
    da_wdata_o  = wdata_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {addr_q[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
    mem_wdata_o = wdata_q;
    unique case (st_q)
      ST_LOOKUP: if (!nc_hit && hit) begin
        da_en_o = 1'b1;
        da_we_o = we_q;
      end
      ST_WB_RD: begin
        da_en_o  = 1'b1;
        da_idx_o = {set_a, way_q, cnt_q};
      end
      ST_WB_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {tag_q[set_a][way_q], set_a, cnt_q, {BYTE_W{1'b0}}};
        mem_wdata_o = da_rdata_i;
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {tag_a, set_a, fill_word_q, {BYTE_W{1'b0}}};
        da_en_o    = mem_ack_i;
        da_we_o    = 1'b1;
        da_idx_o   = {set_a, way_q, fill_word_q};
        // store miss: merge store data into the critical word
        da_wdata_o = (we_q && fill_word_q == word_a) ? wdata_q : mem_rdata_i;
      end
      ST_NC: begin
        mem_req_o = 1'b1;
        mem_we_o  = we_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      tag_q       <= '0;
      valid_q     <= '0;
      dirty_q     <= '0;
      addr_q      <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      way_q       <= '0;
      cnt_q       <= '0;
      fill_word_q <= '0;
      resp_q      <= 1'b0;
    end else begin
      resp_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          addr_q  <= addr_i;
          we_q    <= we_i;
          wdata_q <= wdata_i;
          st_q    <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (nc_hit) begin
            st_q <= ST_NC;
          end else if (hit) begin
            way_q <= hit_way;
            if (we_q) dirty_q[set_a][hit_way] <= 1'b1;
            st_q <= ST_RESP_A;
          end else begin
            way_q       <= victim_way_i;
            cnt_q       <= '0;
            fill_word_q <= word_a;
            st_q <= (valid_q[set_a][victim_way_i] && dirty_q[set_a][victim_way_i])
                    ? ST_WB_RD : ST_FILL;
          end
        end
        ST_RESP_A: begin
          if (!we_q) rdata_q <= da_rdata_i;
          st_q <= ST_RESP_B;
        end
        ST_RESP_B: begin
          resp_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_WB_RD: st_q <= ST_WB_WR;
        ST_WB_WR: if (mem_ack_i) begin
          cnt_q <= cnt_q + 1'b1;
          st_q  <= (cnt_q == LAST_WORD) ? ST_FILL : ST_WB_RD;
        end
        ST_FILL: if (mem_ack_i) begin
          fill_word_q <= fill_word_q + 1'b1;
          cnt_q       <= cnt_q + 1'b1;
          if (!we_q && fill_word_q == word_a) rdata_q <= mem_rdata_i;
          if (cnt_q == LAST_WORD) begin
            tag_q[set_a][way_q]   <= tag_a;
            valid_q[set_a][way_q] <= 1'b1;
            dirty_q[set_a][way_q] <= we_q;
            st_q <= ST_RESP_B;
          end
        end
        ST_NC: if (mem_ack_i) begin
          if (!we_q) rdata_q <= mem_rdata_i;
          st_q <= ST_RESP_B;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: hit completes three edges after lookup starts
  a_r3_hit_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOKUP && hit && !nc_hit) |-> ##3 resp_valid_o);

  // R4: refill word index advances by one, wrapping inside the block
  a_r4_fill_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FILL && mem_ack_i && cnt_q != LAST_WORD) |=>
      (mem_req_o && !mem_we_o &&
       mem_addr_o[OFF_W-1:BYTE_W] == WORD_W'($past(mem_addr_o[OFF_W-1:BYTE_W]) + 1'b1)));

  // R5: store hit leaves the block dirty
  a_r5_store_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOKUP && we_q && hit && !nc_hit) |=> dirty_q[set_a][way_q]);

  // R7: dirty victim: first memory transfer is a write of word 0
  a_r7_wb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOKUP && !nc_hit && !hit &&
     valid_q[set_a][victim_way_i] && dirty_q[set_a][victim_way_i]) |=> ##1
      (mem_req_o && mem_we_o && mem_addr_o[OFF_W-1:BYTE_W] == '0));

  // R9: window access goes to memory without touching the data array
  a_r9_nc_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOKUP && nc_hit) |=> (mem_req_o && !da_en_o));
endmodule

// File: tb/dcache_ctrl_test.sv
`timescale 1ns/1ps
module dcache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic        ready_o, resp_valid_o;
  logic [31:0] rdata_o, geom_o;
  logic [2:0]  victim = '0;
  logic [20:0] nc_base = 21'h01000, nc_limit = 21'h01004;
  logic        da_en_o, da_we_o;
  logic [11:0] da_idx_o;
  logic [31:0] da_wdata_o, da_rdata_i;
  logic        mem_req_o, mem_we_o, mem_ack_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;

  dcache_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ready_o(ready_o), .resp_valid_o(resp_valid_o),
    .rdata_o(rdata_o), .victim_way_i(victim), .nc_base_i(nc_base),
    .nc_limit_i(nc_limit), .geom_o(geom_o), .da_en_o(da_en_o), .da_we_o(da_we_o),
    .da_idx_o(da_idx_o), .da_wdata_o(da_wdata_o), .da_rdata_i(da_rdata_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  initial forever #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] bmem  [logic [31:0]];
  logic [31:0] ref_m [logic [31:0]];
  logic [31:0] dram  [int];
  logic [31:0] log_addr[$], log_data[$];
  logic        log_we[$];
  logic [31:0] exp_data[$];
  bit          exp_chk[$];
  string       exp_req[$];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction
  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return bmem.exists(a) ? bmem[a] : pat(a);
  endfunction
  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return ref_m.exists(a) ? ref_m[a] : pat(a);
  endfunction
  function automatic logic [31:0] mk(input logic [20:0] t, input logic [4:0] s,
                                     input logic [3:0] w);
    return {t, s, w, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder: two-cycle wait per word
  initial begin
    int wcnt;
    wcnt = 0;
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      mem_ack_i = 1'b0;
      if (mem_req_o) begin
        wcnt++;
        if (wcnt >= 2) begin
          wcnt = 0;
          log_addr.push_back(mem_addr_o);
          log_we.push_back(mem_we_o);
          if (mem_we_o) begin
            bmem[mem_addr_o] = mem_wdata_o;
            log_data.push_back(mem_wdata_o);
          end else begin
            mem_rdata_i = mem_rd(mem_addr_o);
            log_data.push_back(mem_rdata_i);
          end
          mem_ack_i = 1'b1;
        end
      end else wcnt = 0;
    end
  end

  // data array model: one-cycle read latency
  initial begin
    logic en, we;
    logic [11:0] idx;
    logic [31:0] wd;
    da_rdata_i = '0;
    forever begin
      @(negedge clk);
      #1;
      en = da_en_o; we = da_we_o; idx = da_idx_o; wd = da_wdata_o;
      @(posedge clk);
      if (en) begin
        if (we) dram[int'(idx)] = wd;
        else da_rdata_i = dram.exists(int'(idx)) ? dram[int'(idx)] : '0;
      end
    end
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (resp_valid_o) begin
      if (exp_data.size() == 0) chk(1'b0, "R12", "unexpected response", rdata_o, '0);
      else begin
        logic [31:0] e;
        bit c;
        string r;
        e = exp_data.pop_front();
        c = exp_chk.pop_front();
        r = exp_req.pop_front();
        if (c) chk(rdata_o == e, r, "load data", rdata_o, e);
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input string req, output int lat);
    while (!ready_o) @(negedge clk);
    log_addr.delete(); log_data.delete(); log_we.delete();
    if (we) begin
      ref_m[a] = d;
      exp_data.push_back('0); exp_chk.push_back(1'b0);
    end else begin
      exp_data.push_back(ref_rd(a)); exp_chk.push_back(1'b1);
    end
    exp_req.push_back(req);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    req_i = 1'b0;
    while (!resp_valid_o && lat < 3000) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    if (lat >= 3000) chk(1'b0, req, "no response", 32'(lat), '0);
  endtask

  task automatic chk_fill(input logic [20:0] t, input logic [4:0] s, input logic [3:0] w0,
                          input int first, input string req);
    bit ok;
    ok = (log_addr.size() == first + 16);
    for (int i = 0; i < 16 && ok; i++) begin
      ok = !log_we[first+i] && log_addr[first+i] == mk(t, s, 4'(int'(w0) + i));
    end
    chk(ok, req, "refill sequence", 32'(log_addr.size()), 32'(first + 16));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R12", "watchdog", '0, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [20:0] TA = 21'h00012, TB = 21'h00034, TC = 21'h00056, TD = 21'h00078;

  initial begin
    int lat;
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready_o == 1'b1, "R1", "ready after reset", 32'(ready_o), 1);
    chk(resp_valid_o == 1'b0 && mem_req_o == 1'b0, "R1", "idle outputs",
        {resp_valid_o, mem_req_o}, 0);
    chk(geom_o == 32'h0020_0840, "R11", "geometry", geom_o, 32'h0020_0840);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R8: first load misses, critical word first, no write-back
    victim = 3'd0;
    access(1'b0, mk(TA, 5'd3, 4'd5), '0, "R4", lat);
    chk_fill(TA, 5'd3, 4'd5, 0, "R4");

    // R3 load hit
    access(1'b0, mk(TA, 5'd3, 4'd9), '0, "R3", lat);
    chk(lat == 3 && log_addr.size() == 0, "R3", "load hit latency", 32'(lat), 3);

    // R5 store hit, copyback
    access(1'b1, mk(TA, 5'd3, 4'd7), 32'hDEAD_0007, "R5", lat);
    chk(lat == 3 && log_addr.size() == 0, "R5", "store hit no traffic", 32'(lat), 3);
    access(1'b0, mk(TA, 5'd3, 4'd7), '0, "R5", lat);

    // R6 store miss allocates, memory untouched
    victim = 3'd1;
    access(1'b1, mk(TB, 5'd3, 4'd2), 32'hBEEF_0002, "R6", lat);
    chk_fill(TB, 5'd3, 4'd2, 0, "R6");
    chk(mem_rd(mk(TB, 5'd3, 4'd2)) == pat(mk(TB, 5'd3, 4'd2)), "R6", "memory unchanged",
        mem_rd(mk(TB, 5'd3, 4'd2)), pat(mk(TB, 5'd3, 4'd2)));
    access(1'b0, mk(TB, 5'd3, 4'd2), '0, "R6", lat);
    chk(lat == 3, "R6", "allocated block hits", 32'(lat), 3);

    // R7 R2 dirty victim in the same set written back first
    victim = 3'd0;
    access(1'b0, mk(TC, 5'd3, 4'd0), '0, "R7", lat);
    ok = log_addr.size() == 32;
    for (int i = 0; i < 16 && ok; i++) begin
      ok = log_we[i] && log_addr[i] == mk(TA, 5'd3, 4'(i)) &&
           log_data[i] == ((i == 7) ? 32'hDEAD_0007 : pat(mk(TA, 5'd3, 4'(i))));
    end
    chk(ok, "R7", "write-back burst", 32'(log_addr.size()), 32);
    chk_fill(TC, 5'd3, 4'd0, 16, "R2");
    chk(mem_rd(mk(TA, 5'd3, 4'd7)) == 32'hDEAD_0007, "R7", "stored word in memory",
        mem_rd(mk(TA, 5'd3, 4'd7)), 32'hDEAD_0007);

    // R13 other way survives
    access(1'b0, mk(TB, 5'd3, 4'd2), '0, "R13", lat);
    chk(lat == 3 && log_addr.size() == 0, "R13", "untouched way hits", 32'(lat), 3);

    // R8 clean victim: no write-back
    victim = 3'd0;
    access(1'b0, mk(TD, 5'd3, 4'd3), '0, "R8", lat);
    chk_fill(TD, 5'd3, 4'd3, 0, "R8");

    // R12 evicted data comes back from memory
    access(1'b0, mk(TA, 5'd3, 4'd7), '0, "R12", lat);
    chk_fill(TA, 5'd3, 4'd7, 0, "R12");

    // R9 non-cacheable store and loads
    access(1'b1, mk(21'h01000, 5'd0, 4'd1), 32'h1111_0001, "R9", lat);
    chk(log_addr.size() == 1 && log_we[0] && log_addr[0] == mk(21'h01000, 5'd0, 4'd1),
        "R9", "single write", 32'(log_addr.size()), 1);
    access(1'b0, mk(21'h01000, 5'd0, 4'd1), '0, "R9", lat);
    chk(log_addr.size() == 1 && !log_we[0], "R9", "single read", 32'(log_addr.size()), 1);
    access(1'b0, mk(21'h01000, 5'd0, 4'd1), '0, "R9", lat);
    chk(log_addr.size() == 1, "R9", "not allocated", 32'(log_addr.size()), 1);

    // R10 window edges
    victim = 3'd2;
    access(1'b0, mk(21'h01003, 5'd1, 4'd4), '0, "R10", lat);
    chk(log_addr.size() == 1, "R10", "limit-1 bypasses", 32'(log_addr.size()), 1);
    access(1'b0, mk(21'h01004, 5'd1, 4'd4), '0, "R10", lat);
    chk(log_addr.size() == 16, "R10", "limit is cacheable", 32'(log_addr.size()), 16);
    access(1'b0, mk(21'h00FFF, 5'd2, 4'd0), '0, "R10", lat);
    chk(log_addr.size() == 16, "R10", "base-1 is cacheable", 32'(log_addr.size()), 16);

    repeat (4) @(negedge clk);
    chk(exp_data.size() == 0, "R12", "responses outstanding", 32'(exp_data.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule